// File: doc/BRIEF.md
# Double-Rate Four-Port Sample Buffer

This buffer holds the samples for one stage of a pipelined radix-4 FFT. A radix-4 butterfly works at the datapath rate and needs all four of its operands in every datapath cycle, so the block offers four logical access ports per cycle. Each port has its own address, write enable, write data and read data. The storage is one true dual-port array. That array is clocked at twice the datapath rate, and each physical port is time-shared between two logical ports.

The first half of a datapath cycle serves logical ports 0 and 1. The second half serves ports 2 and 3. Requests are captured on the slow clock edge and stay fixed while both fast phases run. Read results from the first half are held until the second half has produced its words. All four words then leave together on the next slow edge. The slow and fast clocks must have rising edges that coincide. Reset is asserted asynchronously and released in the second half of a slow cycle.

Top module: `quad_port_buf`

## Requirements
- R1: While reset is asserted, all four read-data words are zero.
- R2: The read word of each port appears at the slow edge after the one that sampled its request. It then holds until the next slow edge, through the middle fast edge.
- R3: Four writes to four distinct addresses in one datapath cycle all take effect.
- R4: A read on port 2 or 3 returns data written in the same datapath cycle by port 0 or 1.
- R5: A read on port 0 or 1 returns the value held before a write in the same datapath cycle by port 2 or 3.
- R6: A read and a write to one address in the same half-cycle return the old value (read-first).
- R7: When ports 0 and 1 write one address in the same cycle, port 1's data is kept. When ports 2 and 3 do so, port 3's data is kept.
- R8: When a port from the first half and a port from the second half write one address in the same cycle, the second-half data is kept.
- R9: The internal phase alternates on every fast edge and is in its second-half state at every slow edge.
- R10: Inputs are only sampled at slow edges. A write enable raised and dropped between two slow edges has no effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_dp | input | 1 | Datapath (slow) clock |
| clk_mem | input | 1 | Memory clock, twice clk_dp, rising edges coincide |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_we | input | 4 | Write enable per logical port, bit p for port p |
| lp_addr | input | 4*ADDR_W | Address per port, port p at bits p*ADDR_W upward |
| lp_wdata | input | 4*DATA_W | Write data per port, port p at bits p*DATA_W upward |
| lp_rdata | output | 4*DATA_W | Read data per port, port p at bits p*DATA_W upward |

## Verification
The phase and hold checks assume a fixed clock relationship. Every clk_dp rising edge must fall on a clk_mem rising edge, and reset must drop after a middle fast edge, so that the first fast edge after release is a slow edge. The bench meets this by producing both clocks from one process, toggling the slow clock on each fast rising edge. It releases reset shortly after a slow falling edge and drives all inputs a fixed time after slow rising edges, away from any fast edge. The one deliberate exception is the R10 pulse, which is placed between the middle fast edge and the next slow edge.

// File: rtl/qpb_pkg.sv
package qpb_pkg;
  localparam int LP_NUM = 4;
  localparam int PHY_NUM = 2;

  typedef enum logic {
    PH_LO = 1'b0,
    PH_HI = 1'b1
  } phase_e;
endpackage

// File: rtl/qpb_phase.sv
module qpb_phase
  import qpb_pkg::*;
(
  input  logic   clk_mem,
  input  logic   rst_n,
  output phase_e ph_q
);
  phase_e ph_d;

  always_comb begin
    ph_d = (ph_q == PH_HI) ? PH_LO : PH_HI;
  end

  always_ff @(posedge clk_mem or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_HI;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/qpb_port_mux.sv
module qpb_port_mux
  import qpb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  phase_e                      ph,
  input  logic [LP_NUM-1:0]           req_we,
  input  logic [LP_NUM*ADDR_W-1:0]    req_addr,
  input  logic [LP_NUM*DATA_W-1:0]    req_wd,
  output logic [PHY_NUM-1:0]          phy_we,
  output logic [PHY_NUM*ADDR_W-1:0]   phy_addr,
  output logic [PHY_NUM*DATA_W-1:0]   phy_wd
);
  logic sel_hi;
  assign sel_hi = (ph == PH_HI);

  for (genvar g = 0; g < PHY_NUM; g++) begin : g_phy
    localparam int LO = g;
    localparam int HI = g + PHY_NUM;
    assign phy_we[g] = sel_hi ? req_we[HI] : req_we[LO];
    assign phy_addr[g*ADDR_W +: ADDR_W] =
      sel_hi ? req_addr[HI*ADDR_W +: ADDR_W] : req_addr[LO*ADDR_W +: ADDR_W];
    assign phy_wd[g*DATA_W +: DATA_W] =
      sel_hi ? req_wd[HI*DATA_W +: DATA_W] : req_wd[LO*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/qpb_dpram.sv
module qpb_dpram
  import qpb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                      clk_mem,
  input  logic [PHY_NUM-1:0]        phy_we,
  input  logic [PHY_NUM*ADDR_W-1:0] phy_addr,
  input  logic [PHY_NUM*DATA_W-1:0] phy_wd,
  output logic [PHY_NUM*DATA_W-1:0] phy_rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic              a_wr, b_wr;

  assign a_addr = phy_addr[0 +: ADDR_W];
  assign b_addr = phy_addr[ADDR_W +: ADDR_W];
  // port B has priority on a same-address double write
  assign b_wr = phy_we[1];
  assign a_wr = phy_we[0] & ~(b_wr & (a_addr == b_addr));

  always_ff @(posedge clk_mem) begin
    if (a_wr) mem[a_addr] <= phy_wd[0 +: DATA_W];
    if (b_wr) mem[b_addr] <= phy_wd[DATA_W +: DATA_W];
  end

  for (genvar g = 0; g < PHY_NUM; g++) begin : g_rd
    assign phy_rd[g*DATA_W +: DATA_W] = mem[phy_addr[g*ADDR_W +: ADDR_W]];
  end
endmodule

// File: rtl/qpb_rd_capture.sv
module qpb_rd_capture
  import qpb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                      clk_mem,
  input  logic                      rst_n,
  input  phase_e                    ph,
  input  logic [PHY_NUM*DATA_W-1:0] phy_rd,
  output logic [LP_NUM*DATA_W-1:0]  rdata_q
);
  logic [PHY_NUM*DATA_W-1:0] lo_q, lo_d;
  logic [LP_NUM*DATA_W-1:0]  rdata_d;
  logic                      lo_en, out_en;

  assign lo_en  = (ph == PH_LO);
  assign out_en = (ph == PH_HI);

  always_comb begin
    lo_d    = lo_en  ? phy_rd           : lo_q;
    rdata_d = out_en ? {phy_rd, lo_q}   : rdata_q;
  end

  always_ff @(posedge clk_mem or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      rdata_q <= '0;
    end else begin
      lo_q    <= lo_d;
      rdata_q <= rdata_d;
    end
  end
endmodule

// File: rtl/quad_port_buf.sv
module quad_port_buf
  import qpb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                     clk_dp,
  input  logic                     clk_mem,
  input  logic                     rst_n,
  input  logic [3:0]               lp_we,
  input  logic [4*ADDR_W-1:0]      lp_addr,
  input  logic [4*DATA_W-1:0]      lp_wdata,
  output logic [4*DATA_W-1:0]      lp_rdata
);
  logic [LP_NUM-1:0]          req_we_q;
  logic [LP_NUM*ADDR_W-1:0]   req_addr_q;
  logic [LP_NUM*DATA_W-1:0]   req_wd_q;
  phase_e                     ph_q;
  logic [PHY_NUM-1:0]         phy_we;
  logic [PHY_NUM*ADDR_W-1:0]  phy_addr;
  logic [PHY_NUM*DATA_W-1:0]  phy_wd;
  logic [PHY_NUM*DATA_W-1:0]  phy_rd;

  // request capture in the datapath domain
  always_ff @(posedge clk_dp or negedge rst_n) begin
    if (!rst_n) begin
      req_we_q   <= '0;
      req_addr_q <= '0;
      req_wd_q   <= '0;
    end else begin
      req_we_q   <= lp_we;
      req_addr_q <= lp_addr;
      req_wd_q   <= lp_wdata;
    end
  end

  qpb_phase u_phase (
    .clk_mem (clk_mem),
    .rst_n   (rst_n),
    .ph_q    (ph_q)
  );

  qpb_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .ph       (ph_q),
    .req_we   (req_we_q),
    .req_addr (req_addr_q),
    .req_wd   (req_wd_q),
    .phy_we   (phy_we),
    .phy_addr (phy_addr),
    .phy_wd   (phy_wd)
  );

  qpb_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk_mem  (clk_mem),
    .phy_we   (phy_we),
    .phy_addr (phy_addr),
    .phy_wd   (phy_wd),
    .phy_rd   (phy_rd)
  );

  qpb_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_mem (clk_mem),
    .rst_n   (rst_n),
    .ph      (ph_q),
    .phy_rd  (phy_rd),
    .rdata_q (lp_rdata)
  );
endmodule

// File: rtl/quad_port_buf_chk.sv
module quad_port_buf_chk #(
  parameter int DATA_W = 16,
  parameter int REQ_W  = 4
) (
  input logic              clk_dp,
  input logic              clk_mem,
  input logic              rst_n,
  input logic              ph,
  input logic [4*DATA_W-1:0] rdata,
  input logic [REQ_W-1:0]  req
);
  // R1
  rst_zero_chk: assert property (@(posedge clk_mem) !rst_n |-> rdata == '0);

  // R9
  ph_align_chk: assert property (@(posedge clk_dp) disable iff (!rst_n) ph == 1'b1);

  // R9
  ph_fall_chk: assert property (@(posedge clk_mem) disable iff (!rst_n) ph |=> !ph);

  // R9
  ph_rise_chk: assert property (@(posedge clk_mem) disable iff (!rst_n) !ph |=> ph);

  // R2
  rd_hold_chk: assert property (@(posedge clk_mem) disable iff (!rst_n) !ph |=> $stable(rdata));

  // R10
  req_hold_chk: assert property (@(posedge clk_mem) disable iff (!rst_n) !ph |=> $stable(req));
endmodule

bind quad_port_buf quad_port_buf_chk #(
  .DATA_W (DATA_W),
  .REQ_W  (4 + 4*ADDR_W + 4*DATA_W)
) u_chk (
  .clk_dp  (clk_dp),
  .clk_mem (clk_mem),
  .rst_n   (rst_n),
  .ph      (ph_q),
  .rdata   (lp_rdata),
  .req     ({req_we_q, req_addr_q, req_wd_q})
);

// File: tb/quad_port_buf_bench.sv
`timescale 1ns/1ps
module quad_port_buf_bench;
  logic        clk_dp, clk_mem, rst_n;
  logic [3:0]  lp_we;
  logic [15:0] lp_addr;
  logic [63:0] lp_wdata;
  logic [63:0] lp_rdata;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] model [16];
  logic [15:0] prev_e [4];
  string       prev_tag = "";

  quad_port_buf u_quad_port_buf (
    .clk_dp   (clk_dp),
    .clk_mem  (clk_mem),
    .rst_n    (rst_n),
    .lp_we    (lp_we),
    .lp_addr  (lp_addr),
    .lp_wdata (lp_wdata),
    .lp_rdata (lp_rdata)
  );

  // one process makes both clocks: slow 200 MHz, fast 400 MHz, rising edges coincide
  initial begin
    clk_mem = 1'b0;
    clk_dp  = 1'b0;
    forever begin
      #1.25;
      clk_mem = ~clk_mem;
      if (clk_mem) clk_dp = ~clk_dp;
    end
  end

  task automatic chk(input string rq, input logic [15:0] act, input logic [15:0] exp, input int port);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s port %0d: got %h expected %h", rq, port, act, exp);
    end
  endtask

  // called 1 ns after a slow rising edge
  task automatic step(input logic [3:0] we, input logic [15:0] ad, input logic [63:0] wd,
                      input string tag, input bit glitch);
    logic [15:0] e [4];
    logic [63:0] snap;
    lp_we = we; lp_addr = ad; lp_wdata = wd;
    for (int p = 0; p < 2; p++) e[p] = model[ad[p*4 +: 4]];
    for (int p = 0; p < 2; p++) if (we[p]) model[ad[p*4 +: 4]] = wd[p*16 +: 16];
    for (int p = 2; p < 4; p++) e[p] = model[ad[p*4 +: 4]];
    for (int p = 2; p < 4; p++) if (we[p]) model[ad[p*4 +: 4]] = wd[p*16 +: 16];
    snap = lp_rdata;
    #2.5;
    if (tag != "") begin
      n_tests++;
      if (lp_rdata !== snap) begin
        n_fail++;
        $display("FAIL R2 hold across middle edge: got %h expected %h", lp_rdata, snap);
      end
    end
    if (glitch) begin
      lp_we = 4'hF; lp_addr = 16'hEEEE; lp_wdata = {4{16'hDEAD}};
      #0.5;
      lp_we = we; lp_addr = ad; lp_wdata = wd;
    end
    @(posedge clk_dp);
    #1;
    if (prev_tag != "")
      for (int p = 0; p < 4; p++) chk(prev_tag, lp_rdata[p*16 +: 16], prev_e[p], p);
    prev_e = e;
    prev_tag = tag;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL R2 watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lp_we = '0; lp_addr = '0; lp_wdata = '0;
    repeat (3) @(posedge clk_dp);
    #1;
    for (int p = 0; p < 4; p++) chk("R1", lp_rdata[p*16 +: 16], 16'h0000, p);
    @(negedge clk_dp);
    #0.5;
    rst_n = 1'b1;
    @(posedge clk_dp);
    #1;
    // fill the array: four distinct writes per cycle
    for (int i = 0; i < 4; i++)
      step(4'hF, {4'(4*i+3), 4'(4*i+2), 4'(4*i+1), 4'(4*i)},
           {16'(16'hA000+4*i+3), 16'(16'hA000+4*i+2), 16'(16'hA000+4*i+1), 16'(16'hA000+4*i)},
           "", 1'b0);
    // R3: read all sixteen back
    for (int i = 0; i < 4; i++)
      step(4'h0, {4'(4*i+3), 4'(4*i+2), 4'(4*i+1), 4'(4*i)}, '0, "R3", 1'b0);
    // R4: ports 2/3 read what ports 0/1 wrote this cycle
    step(4'b0011, {4'd6, 4'd5, 4'd6, 4'd5}, {16'h0, 16'h0, 16'h2222, 16'h1111}, "R4", 1'b0);
    // R5: ports 0/1 read old data under ports 2/3 writes
    step(4'b1100, {4'd8, 4'd7, 4'd8, 4'd7}, {16'h4444, 16'h3333, 16'h0, 16'h0}, "R5", 1'b0);
    step(4'h0, {4'd8, 4'd7, 4'd8, 4'd7}, '0, "R5", 1'b0);
    // R6: read-first within one half-cycle
    step(4'b0001, {4'd9, 4'd9, 4'd9, 4'd9}, {16'h0, 16'h0, 16'h0, 16'h5555}, "R6", 1'b0);
    // R7: same-half collisions, higher port wins
    step(4'hF, {4'd11, 4'd11, 4'd10, 4'd10}, {16'h8888, 16'h7777, 16'h6666, 16'h5A5A}, "R7", 1'b0);
    step(4'h0, {4'd11, 4'd10, 4'd11, 4'd10}, '0, "R7", 1'b0);
    // R8: cross-half collisions, second half wins
    step(4'hF, {4'd13, 4'd12, 4'd12, 4'd13}, {16'hBBBB, 16'hAAAA, 16'h9999, 16'hCCCC}, "R8", 1'b0);
    step(4'h0, {4'd13, 4'd12, 4'd13, 4'd12}, '0, "R8", 1'b0);
    // R10: a write pulse between slow edges is never sampled
    step(4'h0, 16'hEEEE, '0, "R10", 1'b1);
    step(4'h0, 16'hEEEE, '0, "R10", 1'b0);
    // R2: random four-port traffic against the array model
    for (int n = 0; n < 3000; n++)
      step(4'($urandom), 16'($urandom), {$urandom, $urandom}, "R2", 1'b0);
    step(4'h0, 16'h0, '0, "", 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule